// File: doc/BRIEF.md
# Sinusoidal Structural Excitation Generator

This block produces a sine excitation command for one collective control-surface axis. The command is added to the normal surface command just ahead of the servo. It runs at the control frame rate: each frame strobe yields one new signed sample. With the default frequency scaling the nominal frame rate is 80 Hz. The sample is the sine of a phase accumulator, multiplied by a frequency-dependent amplitude A(w), an operator gain K and a fade-in weight, and then hard-limited.

The operator picks one of two test types. A dwell holds a single frequency. A sweep ramps the frequency linearly from a lower to an upper value over a power-of-two number of frames and then disengages by itself. The excitation starts on a rising edge of the engage request. It stops, forcing the output to zero, when the disengage condition is raised, when engage is released, or when a sweep completes. Each new engagement restarts the phase and the fade-in ramp.

Samples leave on a valid/ready stream. The frame clock cannot be stalled, so back-pressure never delays the generator. A sample that has not been accepted stays presented with `out_valid` high until `out_ready` is seen. A newer sample, or the zero emitted at disengagement, replaces it.

Top module: `exc_gen`

## Requirements
- R1: After reset `out_sample` is 0, `out_valid` is 0 and `active` is 0; whenever `active` is 0, `out_sample` is 0.
- R2: `active` rises on the clock after a cycle in which `engage` is 1, `engage` was 0 in the previous cycle, and `disengage` is 0; with `disengage` at 1 the edge is ignored, and holding `engage` high does not re-engage.
- R3: While active, each clock with `frame_tick` = 1 produces exactly one new sample, visible after that edge with `out_valid` = 1; between frame ticks the sample does not change.
- R4: The k-th sample after engagement (k = 1, 2, ...) uses phase P(k) = the sum of the increments of samples 1..k-1, where each increment is fw << 16 on a 32-bit wrapping phase. The table angle is phase[31:22], and the sine value is 32767·sin(2π·angle/1024), exact at angles 0, 256, 512 and 768.
- R5: The fade-in weight of sample k is min(k, 64)/64.
- R6: Sample = floor(S·A·K·F / 2^17), clamped to the range −20000..+20000. Here S is the sine value, A the amplitude, K = gain_sel + 1 and F = min(k, 64).
- R7: The amplitude A = 255 − 12·b, where b = fw[14:11] is the frequency word of that sample.
- R8: In dwell (`mode_sel` = 0), fw is the clamped lower frequency for every sample, until disengagement.
- R9: In sweep (`mode_sel` = 1), sample n+1 (n = 0..2^S, S = `sweep_log2`) uses fw = lo + floor((hi − lo)·n / 2^S). The next frame tick then emits a 0 sample and drops `active`.
- R10: `disengage` = 1, or `engage` = 0, while active drops `active` at the next edge, with `out_sample` = 0 and `out_valid` = 1; re-engaging restarts at phase 0 with fade weight 1/64.
- R11: Frequency words are clamped to 410..16384, which is 0.5 Hz to 20 Hz at 80 Hz frames (f = fw·80/65536). If the clamped upper value is below the lower, it is raised to the lower.
- R12: Mode, frequencies, sweep length and gain are captured at engagement; changes while active have no effect on the samples.
- R13: With `out_ready` = 0, `out_valid` stays 1 and the newest sample replaces an unaccepted one. `out_valid` clears on the edge after `out_valid` and `out_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe per control frame |
| engage | input | 1 | Engage request (rising edge starts, low stops) |
| disengage | input | 1 | Automatic disengage condition |
| mode_sel | input | 1 | 0 dwell, 1 sweep |
| freq_lo | input | 15 | Lower / dwell frequency word |
| freq_hi | input | 15 | Upper sweep frequency word |
| sweep_log2 | input | 4 | Sweep length is 2^S frames |
| gain_sel | input | 3 | Gain K = (gain_sel+1)/8 |
| out_sample | output | 16 | Signed excitation sample |
| out_valid | output | 1 | Sample presented |
| out_ready | input | 1 | Consumer accepts sample |
| active | output | 1 | Excitation running |

## Verification
The hardest states to reach are the exact sweep end and the interaction of fade-in with the limiter. Both need long, precisely counted runs of frame ticks under a latched configuration. The bench keeps its own phase accumulator, fade count and sweep counter, derived from the requirements, and compares every sample. Frequencies of 8192 and 16384 put the table angle on exact quadrant points, which allows bit-exact checks of the fade and limit arithmetic. The inputs are scrambled after every engagement to show that they are captured. Back-pressure is tested by withholding ready across two frames.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic {
    MODE_DWELL = 1'b0,
    MODE_SWEEP = 1'b1
  } exc_mode_e;

  // Rational sine approximation over a half period of h steps, scaled to peak.
  function automatic int sine_approx(int x, int h, int peak);
    longint p;
    longint num;
    longint den;
    p   = longint'(x) * longint'(h - x);
    num = longint'(peak) * 16 * p;
    den = 5 * longint'(h) * longint'(h) - 4 * p;
    return int'(num / den);
  endfunction

  // Amplitude schedule: decreases linearly with the frequency band.
  function automatic int amp_of(int band, int base, int slope);
    return base - slope * band;
  endfunction

endpackage

// File: rtl/exc_sine_rom.sv
module exc_sine_rom #(
  parameter int LUT_BITS = 10,
  parameter int SINE_W   = 16
) (
  input  logic [LUT_BITS-1:0]      angle,
  output logic signed [SINE_W-1:0] sine
);
  localparam int QW   = LUT_BITS - 2;
  localparam int QTR  = 1 << QW;
  localparam int PEAK = (1 << (SINE_W - 1)) - 1;

  logic signed [SINE_W-1:0] tab [0:QTR];

  for (genvar j = 0; j <= QTR; j++) begin : g_tab
    assign tab[j] = SINE_W'(exc_pkg::sine_approx(j, 2 * QTR, PEAK));
  end

  logic [1:0]               quad;
  logic [QW-1:0]            pos;
  logic [QW:0]              look;
  logic signed [SINE_W-1:0] mag;

  always_comb begin
    quad = angle[LUT_BITS-1 -: 2];
    pos  = angle[QW-1:0];
    if (quad[0]) look = (QW+1)'(QTR) - {1'b0, pos};
    else         look = {1'b0, pos};
    mag  = tab[look];
    sine = quad[1] ? -mag : mag;
  end
endmodule

// File: rtl/exc_freq_gen.sv
module exc_freq_gen #(
  parameter int FREQ_W  = 15,
  parameter int SHIFT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  exc_pkg::exc_mode_e mode,
  input  logic [FREQ_W-1:0] lo,
  input  logic [FREQ_W-1:0] hi,
  input  logic [SHIFT_W-1:0] shift,
  output logic [FREQ_W-1:0] fw,
  output logic              done
);
  localparam int N_W = (1 << SHIFT_W) + 1;
  localparam int P_W = FREQ_W + N_W;

  logic [N_W-1:0]    n_q;
  logic [FREQ_W-1:0] span;
  logic [P_W-1:0]    prod;
  logic [N_W-1:0]    last;

  always_ff @(posedge clk) begin
    if (!rst_n)     n_q <= '0;
    else if (start) n_q <= '0;
    else if (adv)   n_q <= n_q + 1'b1;
  end

  always_comb begin
    span = hi - lo;
    prod = P_W'(span) * P_W'(n_q);
    last = (N_W'(1) << shift) + N_W'(1);
    if (mode == exc_pkg::MODE_SWEEP) fw = lo + FREQ_W'(prod >> shift);
    else                             fw = lo;
    done = (mode == exc_pkg::MODE_SWEEP) && (n_q == last);
  end
endmodule

// File: rtl/exc_scaler.sv
module exc_scaler #(
  parameter int SINE_W    = 16,
  parameter int AMP_IDX_W = 4,
  parameter int AMP_W     = 8,
  parameter int AMP_BASE  = 255,
  parameter int AMP_SLOPE = 12,
  parameter int GAIN_W    = 3,
  parameter int FADE_LEN  = 64,
  parameter int LIMIT     = 20000
) (
  input  logic signed [SINE_W-1:0]   sine,
  input  logic [AMP_IDX_W-1:0]       band,
  input  logic [GAIN_W-1:0]          gain,
  input  logic [$clog2(FADE_LEN):0]  fade,
  output logic signed [SINE_W-1:0]   sample
);
  localparam int FADE_W  = $clog2(FADE_LEN) + 1;
  localparam int K_W     = GAIN_W + 1;
  localparam int P_W     = SINE_W + AMP_W + K_W + FADE_W + 4;
  localparam int SH      = AMP_W + GAIN_W + $clog2(FADE_LEN);
  localparam int N_BANDS = 1 << AMP_IDX_W;
  localparam logic signed [P_W-1:0] LIM_P = P_W'(LIMIT);

  logic [AMP_W-1:0] amp_tab [N_BANDS];
  for (genvar b = 0; b < N_BANDS; b++) begin : g_amp
    assign amp_tab[b] = AMP_W'(exc_pkg::amp_of(b, AMP_BASE, AMP_SLOPE));
  end

  logic [K_W-1:0]          kval;
  logic signed [P_W-1:0]   s_x, a_x, k_x, f_x, prod, scaled;

  always_comb begin
    kval   = {1'b0, gain} + K_W'(1);
    s_x    = {{(P_W-SINE_W){sine[SINE_W-1]}}, sine};
    a_x    = {{(P_W-AMP_W){1'b0}}, amp_tab[band]};
    k_x    = {{(P_W-K_W){1'b0}}, kval};
    f_x    = {{(P_W-FADE_W){1'b0}}, fade};
    prod   = s_x * a_x * k_x * f_x;
    scaled = prod >>> SH;
    if (scaled > LIM_P)       sample = SINE_W'(LIM_P);
    else if (scaled < -LIM_P) sample = SINE_W'(-LIM_P);
    else                      sample = SINE_W'(scaled);
  end
endmodule

// File: rtl/exc_gen.sv
module exc_gen #(
  parameter int PHASE_W   = 32,
  parameter int FREQ_W    = 15,
  parameter int SINE_W    = 16,
  parameter int LUT_BITS  = 10,
  parameter int GAIN_W    = 3,
  parameter int SHIFT_W   = 4,
  parameter int AMP_IDX_W = 4,
  parameter int AMP_W     = 8,
  parameter int FADE_LEN  = 64,
  parameter int FW_MIN    = 410,
  parameter int FW_MAX    = 16384,
  parameter int LIMIT     = 20000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_tick,
  input  logic                     engage,
  input  logic                     disengage,
  input  logic                     mode_sel,
  input  logic [FREQ_W-1:0]        freq_lo,
  input  logic [FREQ_W-1:0]        freq_hi,
  input  logic [SHIFT_W-1:0]       sweep_log2,
  input  logic [GAIN_W-1:0]        gain_sel,
  output logic signed [SINE_W-1:0] out_sample,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     active
);
  import exc_pkg::*;

  localparam int INC_SH = PHASE_W - FREQ_W - 1;
  localparam int FADE_W = $clog2(FADE_LEN) + 1;
  localparam logic [FREQ_W-1:0] F_MIN = FREQ_W'(FW_MIN);
  localparam logic [FREQ_W-1:0] F_MAX = FREQ_W'(FW_MAX);

  // Configuration captured at engagement
  exc_mode_e          mode_q;
  logic [FREQ_W-1:0]  lo_q, hi_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [GAIN_W-1:0]  gain_q;

  logic                     engage_d, active_q, valid_q;
  logic [PHASE_W-1:0]       phase_q;
  logic [FADE_W-1:0]        fade_q, fade_w;
  logic signed [SINE_W-1:0] sample_q;

  logic [FREQ_W-1:0] lo_c, hi_c, hi_e;
  logic              accept, leave, adv, done;
  logic [FREQ_W-1:0] fw;
  logic signed [SINE_W-1:0] sine, scaled;
  logic [PHASE_W-1:0] inc;

  function automatic logic [FREQ_W-1:0] clampf(logic [FREQ_W-1:0] v);
    if (v < F_MIN)      return F_MIN;
    else if (v > F_MAX) return F_MAX;
    else                return v;
  endfunction

  always_comb begin
    lo_c   = clampf(freq_lo);
    hi_c   = clampf(freq_hi);
    hi_e   = (hi_c < lo_c) ? lo_c : hi_c;
    accept = !active_q && engage && !engage_d && !disengage;
    leave  = active_q && (disengage || !engage);
    adv    = active_q && !leave && frame_tick && !done;
    fade_w = (fade_q == FADE_W'(FADE_LEN)) ? fade_q : fade_q + 1'b1;
    inc    = PHASE_W'(fw) << INC_SH;
  end

  exc_freq_gen #(.FREQ_W(FREQ_W), .SHIFT_W(SHIFT_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .start(accept), .adv(adv),
    .mode(mode_q), .lo(lo_q), .hi(hi_q), .shift(shift_q),
    .fw(fw), .done(done)
  );

  exc_sine_rom #(.LUT_BITS(LUT_BITS), .SINE_W(SINE_W)) u_rom (
    .angle(phase_q[PHASE_W-1 -: LUT_BITS]), .sine(sine)
  );

  exc_scaler #(
    .SINE_W(SINE_W), .AMP_IDX_W(AMP_IDX_W), .AMP_W(AMP_W),
    .GAIN_W(GAIN_W), .FADE_LEN(FADE_LEN), .LIMIT(LIMIT)
  ) u_scale (
    .sine(sine), .band(fw[FREQ_W-1 -: AMP_IDX_W]), .gain(gain_q),
    .fade(fade_w), .sample(scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      engage_d <= 1'b0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
      phase_q  <= '0;
      fade_q   <= '0;
      mode_q   <= MODE_DWELL;
      lo_q     <= F_MIN;
      hi_q     <= F_MIN;
      shift_q  <= '0;
      gain_q   <= '0;
    end else begin
      engage_d <= engage;
      if (valid_q && out_ready) valid_q <= 1'b0;
      if (accept) begin
        active_q <= 1'b1;
        phase_q  <= '0;
        fade_q   <= '0;
        mode_q   <= exc_mode_e'(mode_sel);
        lo_q     <= lo_c;
        hi_q     <= hi_e;
        shift_q  <= sweep_log2;
        gain_q   <= gain_sel;
      end else if (leave) begin
        active_q <= 1'b0;
        sample_q <= '0;
        valid_q  <= 1'b1;
      end else if (active_q && frame_tick) begin
        valid_q <= 1'b1;
        if (done) begin
          active_q <= 1'b0;
          sample_q <= '0;
        end else begin
          sample_q <= scaled;
          phase_q  <= phase_q + inc;
          fade_q   <= fade_w;
        end
      end
    end
  end

  assign out_sample = sample_q;
  assign out_valid  = valid_q;
  assign active     = active_q;
endmodule

// File: rtl/exc_gen_chk.sv
module exc_gen_chk #(
  parameter int SINE_W = 16,
  parameter int LIMIT  = 20000
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_tick,
  input logic                     engage,
  input logic                     disengage,
  input logic signed [SINE_W-1:0] out_sample,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic                     active
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> out_sample == '0);  // R1

  AST_ENGAGE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(engage && !disengage));  // R2

  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    active && !frame_tick && engage && !disengage |=> $stable(out_sample));  // R3

  AST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(out_sample) <= LIMIT) && (int'(out_sample) >= -LIMIT));  // R6

  AST_DISENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
    active && (disengage || !engage) |=> !active && out_valid);  // R10

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);  // R13

  AST_VALID_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frame_tick && !active |=> !out_valid);  // R13
endmodule

bind exc_gen exc_gen_chk #(.SINE_W(SINE_W), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .engage(engage),
  .disengage(disengage), .out_sample(out_sample), .out_valid(out_valid),
  .out_ready(out_ready), .active(active)
);

// File: tb/tb_exc_gen.sv
module tb_exc_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, engage = 1'b0, disengage = 1'b0, mode_sel = 1'b0;
  logic [14:0] freq_lo = 15'd410, freq_hi = 15'd410;
  logic [3:0]  sweep_log2 = 4'd0;
  logic [2:0]  gain_sel = 3'd0;
  logic signed [15:0] out_sample;
  logic out_valid, out_ready = 1'b1, active;

  int n_checks = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  exc_gen dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .engage(engage),
    .disengage(disengage), .mode_sel(mode_sel), .freq_lo(freq_lo),
    .freq_hi(freq_hi), .sweep_log2(sweep_log2), .gain_sel(gain_sel),
    .out_sample(out_sample), .out_valid(out_valid), .out_ready(out_ready),
    .active(active)
  );

  // Stimulus vectors: mode, lo, hi, log2 length, gain, dwell frames, tag
  localparam int NV = 8;
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 1, 0};
  localparam int V_LO   [NV] = '{8192, 410, 100, 30000, 410, 5000, 2000, 6000};
  localparam int V_HI   [NV] = '{0, 0, 0, 0, 16384, 1000, 12000, 0};
  localparam int V_S    [NV] = '{0, 0, 0, 0, 5, 3, 6, 0};
  localparam int V_G    [NV] = '{7, 3, 0, 5, 7, 2, 6, 4};
  localparam int V_LEN  [NV] = '{80, 70, 20, 20, 0, 0, 0, 30};
  localparam string V_TAG [NV] = '{"R6", "R4", "R11", "R5", "R9", "R12", "R7", "R8"};

  task automatic chk(string tag, int act, int exp, int tol);
    int d;
    n_checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampf(int v);
    if (v < 410) return 410;
    if (v > 16384) return 16384;
    return v;
  endfunction

  // Expected sample from the requirement formulas (R4..R7)
  function automatic int model(logic [31:0] ph, int fw, int g, int fade, output int tol);
    int th, a, k, e, s;
    longint p;
    real r;
    th = int'(ph[31:22]);
    a  = 255 - 12 * (fw >> 11);
    k  = g + 1;
    if (th % 256 == 0) begin
      s = (th == 256) ? 32767 : (th == 768) ? -32767 : 0;
      p = longint'(s) * a * k * fade;
      e = int'(p >>> 17);
      tol = 0;
    end else begin
      r = 32767.0 * $sin(2.0 * 3.14159265358979 * th / 1024.0) * a * k * fade / 131072.0;
      e = $rtoi($floor(r));
      tol = 60;
    end
    if (e > 20000) e = 20000;
    if (e < -20000) e = -20000;
    return e;
  endfunction

  task automatic tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic do_engage();
    @(negedge clk) engage = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_all();
    @(negedge clk) engage = 1'b0; disengage = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [31:0] ph;
    int lo, hi, fw, nsamp, e, tol, g;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(out_sample), 0, 0);
    chk("R1", int'(active), 0, 0);
    chk("R1", int'(out_valid), 0, 0);

    // R2: edge ignored while disengage high; held engage does not re-engage
    disengage = 1'b1;
    do_engage();
    chk("R2", int'(active), 0, 0);
    @(negedge clk) disengage = 1'b0;
    @(negedge clk);
    chk("R2", int'(active), 0, 0);
    release_all();

    // Vector table loop
    for (int v = 0; v < NV; v++) begin
      mode_sel = V_MODE[v][0];
      freq_lo = 15'(V_LO[v]);
      freq_hi = 15'(V_HI[v]);
      sweep_log2 = 4'(V_S[v]);
      gain_sel = 3'(V_G[v]);
      do_engage();
      chk("R2", int'(active), 1, 0);
      // R12: scramble every setting after capture
      freq_lo = ~freq_lo;
      freq_hi = 15'd777;
      mode_sel = ~mode_sel;
      sweep_log2 = 4'd15;
      gain_sel = ~gain_sel;
      lo = clampf(V_LO[v]);
      hi = clampf(V_HI[v]);
      if (hi < lo) hi = lo;
      nsamp = (V_MODE[v] == 1) ? (1 << V_S[v]) + 1 : V_LEN[v];
      ph = 32'd0;
      for (int k = 1; k <= nsamp; k++) begin
        if (V_MODE[v] == 1) fw = lo + (((hi - lo) * (k - 1)) >> V_S[v]);
        else fw = lo;
        tick();
        e = model(ph, fw, V_G[v], (k < 64) ? k : 64, tol);
        chk(V_TAG[v], int'(out_sample), e, tol);
        chk("R3", int'(out_valid), 1, 0);
        ph = ph + {1'b0, 15'(fw), 16'd0};
      end
      if (V_MODE[v] == 1) begin
        tick();
        chk("R9", int'(out_sample), 0, 0);
        chk("R9", int'(active), 0, 0);
      end else begin
        @(negedge clk) engage = 1'b0;
        @(negedge clk);
        chk("R10", int'(active), 0, 0);
        chk("R10", int'(out_sample), 0, 0);
      end
      release_all();
    end

    // R10: disengage mid-run, then restart from phase 0 / fade 1
    mode_sel = 1'b0; freq_lo = 15'd16384; gain_sel = 3'd5;
    do_engage();
    repeat (5) tick();
    @(negedge clk) disengage = 1'b1;
    @(negedge clk);
    chk("R10", int'(active), 0, 0);
    chk("R10", int'(out_sample), 0, 0);
    chk("R10", int'(out_valid), 1, 0);
    release_all();
    do_engage();
    tick();
    chk("R10", int'(out_sample), 0, 0);
    tick();
    e = model(32'h4000_0000, 16384, 5, 2, tol);
    chk("R10", int'(out_sample), e, 0);
    release_all();

    // R13: back-pressure holds valid and replaces the pending sample
    gain_sel = 3'd7;
    do_engage();
    out_ready = 1'b0;
    tick();
    chk("R13", int'(out_valid), 1, 0);
    tick();
    repeat (3) @(negedge clk);
    g = 7;
    e = model(32'h4000_0000, 16384, g, 2, tol);
    chk("R13", int'(out_valid), 1, 0);
    chk("R13", int'(out_sample), e, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R13", int'(out_valid), 0, 0);
    release_all();

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule